// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block brings a clock generator from power-off to normal clocking and captures its configuration straps exactly once on the way. It watches an analog-supply-good flag. It then waits a fixed number of timebase ticks for the supply to settle. After that it waits for a dual-use pin to go low, which signals that the processor's termination supply is stable. At that moment it samples three frequency-select straps, a test-select strap and a strap that chooses what the shared differential pair carries. It then counts a modelled PLL lock delay before it enables the outputs.

Once the straps are held, the same pin changes meaning. A high level on it becomes a live, active-high power-down request. Every power-down clears the lock wait, so outputs come back only after a full relock. While the held test strap is set, the strap strobe stays live: every low level on the pin reloads all straps. Dropping the supply-good flag returns the block to power-off and forgets the straps.

All delays are counted in ticks of an external slow timebase, and the tick counts are parameters. The pin passes through a two-flop synchronizer before any decision is made on it. The strap pins are assumed to be static around the strobe.

Top module: `pwrgd_strap_seq`

## Requirements
- R1: After reset: `fsel_q`=000, `freq_code`=7 (reserved/none), `test_hiz`=0, `pair_is_cpu`=0, `outputs_en`=0, `pwr_down`=0.
- R2: The held code decodes as `freq_code` = 0 for {C,B,A}=101 (100 MHz), 1 for 001 (133), 2 for 011 (166), 3 for 010 (200), 4 for 000 (266), 5 for 100 (333), 6 for 110 (400) and 7 for 111 (reserved).
- R3: After `avdd_ok` rises, the straps are not sampled until `SUPPLY_TICKS` ticks have been counted, even when the pin is already low.
- R4: After the supply wait, the first synchronized low on `pg_pin` loads the straps. `fsel_q` = `fsel_pin`, where bit 2 is C, bit 1 is B and bit 0 is A. `test_hiz` = `tsel_pin`. `pair_is_cpu` = `pair_sel_pin`, where 1 routes the pair as CPU2 and 0 routes it as SRC6.
- R5: Once loaded with `test_hiz`=0, the held straps do not change on later pin pulses or strap changes.
- R6: While `test_hiz`=1, each cycle in which the synchronized pin is low reloads all straps, including the test strap itself.
- R7: `pwr_down` is 0 before the straps are held, even when the pin is high. After they are held, `pwr_down` follows a high pin two clocks later.
- R8: `outputs_en` rises only after `LOCK_TICKS` ticks have been counted in the lock state with no power-down, and then stays high.
- R9: While `pwr_down` is 1, `outputs_en` is 0. A power-down that arrives before the outputs are enabled keeps them off. Each release of power-down restarts the full lock wait.
- R10: When `avdd_ok` is low at a clock edge, the block returns to power-off and all outputs take their R1 values at the next edge. A later power-up samples fresh straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse of the slow timebase |
| avdd_ok | input | 1 | Analog supply good, synchronous |
| pg_pin | input | 1 | Dual-use pin: active-low power-good strobe, then active-high power-down |
| fsel_pin | input | 3 | Frequency-select straps {C,B,A} |
| tsel_pin | input | 1 | Test-select strap |
| pair_sel_pin | input | 1 | Shared pair routing strap |
| fsel_q | output | 3 | Held frequency-select value, read-only control bits |
| freq_code | output | 3 | Decoded CPU frequency code |
| test_hiz | output | 1 | Tri-state all outputs for test |
| pair_is_cpu | output | 1 | 1 = shared pair is CPU2, 0 = SRC6 |
| outputs_en | output | 1 | Clock outputs enabled |
| pwr_down | output | 1 | Live power-down request |

## Verification
The bench holds the pin low before the supply comes up. A design that sampled during the supply wait would latch too early, and the bench checks that nothing is held just short of the tick count. It pulses the pin and changes the straps after the latch, both outside and inside test mode. A missing one-shot shows up as changed held values, and a missing test-mode reload shows up as stale ones. It raises power-down before the outputs are ever enabled and again after they are running. A design that kept its lock count across a power-down would re-enable too soon after release. Randomised power cycles confirm that the straps are forgotten and sampled afresh each time.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SUPPLY = 2'd1,
    ST_STRAP  = 2'd2,
    ST_LOCK   = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    FQ_100 = 3'd0,
    FQ_133 = 3'd1,
    FQ_166 = 3'd2,
    FQ_200 = 3'd3,
    FQ_266 = 3'd4,
    FQ_333 = 3'd5,
    FQ_400 = 3'd6,
    FQ_RSV = 3'd7
  } freq_code_e;

  typedef struct packed {
    logic [2:0] fsel;
    logic       tsel;
    logic       pair_cpu;
  } strap_t;

  // {C,B,A} strap pattern to CPU frequency code
  function automatic freq_code_e decode_fsel(input logic [2:0] cba);
    freq_code_e r;
    unique case (cba)
      3'b101:  r = FQ_100;
      3'b001:  r = FQ_133;
      3'b011:  r = FQ_166;
      3'b010:  r = FQ_200;
      3'b000:  r = FQ_266;
      3'b100:  r = FQ_333;
      3'b110:  r = FQ_400;
      default: r = FQ_RSV;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pgseq_sync.sv
module pgseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pgseq_tick_timer.sv
module pgseq_tick_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  assign done = (cnt_q == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (tick && !done) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pgseq_strap_latch.sv
module pgseq_strap_latch
  import pgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  strap_t     pins,
  output strap_t     held,
  output logic [2:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      code <= FQ_RSV;
    end else if (clear) begin
      held <= '0;
      code <= FQ_RSV;
    end else if (load) begin
      held <= pins;
      code <= decode_fsel(pins.fsel);
    end
  end
endmodule

// File: rtl/pwrgd_strap_seq.sv
module pwrgd_strap_seq
  import pgseq_pkg::*;
#(
  parameter int SUPPLY_TICKS = 260,
  parameter int LOCK_TICKS   = 1800,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avdd_ok,
  input  logic       pg_pin,
  input  logic [2:0] fsel_pin,
  input  logic       tsel_pin,
  input  logic       pair_sel_pin,
  output logic [2:0] fsel_q,
  output logic [2:0] freq_code,
  output logic       test_hiz,
  output logic       pair_is_cpu,
  output logic       outputs_en,
  output logic       pwr_down
);
  seq_state_e state_q, state_d;
  logic   pg_sync;
  logic   sup_done, lock_done, lock_clear;
  logic   latched, pd_live;
  logic   first_strobe, test_reload, strap_load;
  strap_t pins, held;
  logic [2:0] code_q;

  // pin is high (not yet power-good) out of reset
  pgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .d(pg_pin), .q(pg_sync)
  );

  // named internal events
  assign latched      = (state_q == ST_LOCK);
  assign pd_live      = latched & pg_sync;
  assign first_strobe = (state_q == ST_STRAP) & ~pg_sync & avdd_ok;
  assign test_reload  = latched & held.tsel & ~pg_sync & avdd_ok;
  assign strap_load   = first_strobe | test_reload;
  assign lock_clear   = ~latched | pd_live;

  pgseq_tick_timer #(.LIMIT(SUPPLY_TICKS)) u_sup_tmr (
    .clk(clk), .rst_n(rst_n), .clear(state_q != ST_SUPPLY),
    .tick(tick), .done(sup_done)
  );

  pgseq_tick_timer #(.LIMIT(LOCK_TICKS)) u_lock_tmr (
    .clk(clk), .rst_n(rst_n), .clear(lock_clear),
    .tick(tick), .done(lock_done)
  );

  always_comb begin
    state_d = state_q;
    if (!avdd_ok) state_d = ST_OFF;
    else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_SUPPLY;
        ST_SUPPLY: if (sup_done) state_d = ST_STRAP;
        ST_STRAP:  if (!pg_sync) state_d = ST_LOCK;
        ST_LOCK:   state_d = ST_LOCK;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign pins = '{fsel: fsel_pin, tsel: tsel_pin, pair_cpu: pair_sel_pin};

  pgseq_strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clear(~avdd_ok), .load(strap_load),
    .pins(pins), .held(held), .code(code_q)
  );

  assign fsel_q      = held.fsel;
  assign freq_code   = code_q;
  assign test_hiz    = held.tsel;
  assign pair_is_cpu = held.pair_cpu;
  assign pwr_down    = pd_live;
  assign outputs_en  = latched & lock_done & ~pd_live;
endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker
  import pgseq_pkg::*;
#(
  parameter int SUPPLY_TICKS = 260,
  parameter int LOCK_TICKS   = 1800
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       avdd_ok,
  input seq_state_e state,
  input logic       pg_sync,
  input logic       latched,
  input logic [2:0] fsel_pin,
  input logic [2:0] fsel_q,
  input logic [2:0] freq_code,
  input logic       test_hiz,
  input logic       pair_is_cpu,
  input logic       outputs_en,
  input logic       pwr_down
);
  logic [15:0] sup_ticks, lock_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_ticks <= '0;
    else if (state != ST_SUPPLY) begin
      if (state != ST_STRAP) sup_ticks <= '0;
    end else if (tick && sup_ticks != 16'hFFFF) sup_ticks <= sup_ticks + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_ticks <= '0;
    else if (state != ST_LOCK || pwr_down) lock_ticks <= '0;
    else if (tick && lock_ticks != 16'hFFFF) lock_ticks <= lock_ticks + 16'd1;
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !avdd_ok |=> (freq_code == 3'd7 && fsel_q == 3'd0 && !test_hiz &&
                  !pair_is_cpu && !outputs_en && !pwr_down)); // R10

  AST_SUPPLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_SUPPLY && state == ST_STRAP) |->
      sup_ticks >= 16'(SUPPLY_TICKS)); // R3

  AST_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> ($past(!pg_sync) && fsel_q == $past(fsel_pin))); // R4

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !test_hiz && avdd_ok) |=>
      ($stable(fsel_q) && $stable(pair_is_cpu) && $stable(test_hiz))); // R5

  AST_CODE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> freq_code == 3'(decode_fsel(fsel_q))); // R2

  AST_EN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outputs_en) |-> lock_ticks >= 16'(LOCK_TICKS)); // R8

  AST_PD_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |=> !outputs_en); // R9

  AST_NO_EARLY_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LOCK) |-> !pwr_down); // R7
endmodule

bind pwrgd_strap_seq pgseq_checker #(
  .SUPPLY_TICKS(SUPPLY_TICKS), .LOCK_TICKS(LOCK_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .avdd_ok(avdd_ok),
  .state(state_q), .pg_sync(pg_sync), .latched(latched),
  .fsel_pin(fsel_pin), .fsel_q(fsel_q), .freq_code(freq_code),
  .test_hiz(test_hiz), .pair_is_cpu(pair_is_cpu),
  .outputs_en(outputs_en), .pwr_down(pwr_down)
);

// File: tb/tb_pwrgd_strap_seq.sv
module tb_pwrgd_strap_seq;
  localparam int SUP  = 6;
  localparam int LOCK = 10;
  localparam int TP   = 3;   // clocks per tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic avdd_ok = 1'b0;
  logic pg_pin = 1'b1;
  logic [2:0] fsel_pin = 3'b000;
  logic tsel_pin = 1'b0;
  logic pair_sel_pin = 1'b0;
  logic [2:0] fsel_q, freq_code;
  logic test_hiz, pair_is_cpu, outputs_en, pwr_down;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrgd_strap_seq #(.SUPPLY_TICKS(SUP), .LOCK_TICKS(LOCK), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avdd_ok(avdd_ok), .pg_pin(pg_pin),
    .fsel_pin(fsel_pin), .tsel_pin(tsel_pin), .pair_sel_pin(pair_sel_pin),
    .fsel_q(fsel_q), .freq_code(freq_code), .test_hiz(test_hiz),
    .pair_is_cpu(pair_is_cpu), .outputs_en(outputs_en), .pwr_down(pwr_down)
  );

  // timebase: one-cycle pulse every TP clocks
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % TP;
      tick = (c == 0);
    end
  end

  function automatic int exp_code(input logic [2:0] cba);
    case (cba)
      3'b101: return 0;
      3'b001: return 1;
      3'b011: return 2;
      3'b010: return 3;
      3'b000: return 4;
      3'b100: return 5;
      3'b110: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_off(input string tag);
    chk({tag, " code"}, freq_code, 7);
    chk({tag, " fsel"}, fsel_q, 0);
    chk({tag, " hiz"}, test_hiz, 0);
    chk({tag, " pair"}, pair_is_cpu, 0);
    chk({tag, " en"}, outputs_en, 0);
    chk({tag, " pd"}, pwr_down, 0);
  endtask

  // power-off, then full power-up with the given straps, pin held low
  task automatic power_up(input logic [2:0] fs, input logic ts, input logic ps);
    avdd_ok = 1'b0; pg_pin = 1'b1;
    waitn(2);
    fsel_pin = fs; tsel_pin = ts; pair_sel_pin = ps; pg_pin = 1'b0;
    avdd_ok = 1'b1;
    waitn(SUP * TP + 8);
    waitn((LOCK + 2) * TP + 8);
  endtask

  initial begin
    void'($urandom(32'd4471));
    waitn(4);
    check_off("R1 reset");
    rst_n = 1'b1;
    waitn(2);
    check_off("R1 after reset");

    // R7: pin high while not latched is not a power-down
    avdd_ok = 1'b1; pg_pin = 1'b1;
    waitn((SUP + 3) * TP + 6);
    chk("R7 no pd before latch", pwr_down, 0);
    chk("R7 not latched", freq_code, 7);

    // R3: pin already low when supply rises, no early sample
    avdd_ok = 1'b0; waitn(2);
    fsel_pin = 3'b011; pair_sel_pin = 1'b1; tsel_pin = 1'b0; pg_pin = 1'b0;
    avdd_ok = 1'b1;
    waitn((SUP - 1) * TP + 2);
    chk("R3 not sampled early", freq_code, 7);
    waitn(TP + 7);
    chk("R4 fsel held", fsel_q, 3'b011);
    chk("R4 pair cpu", pair_is_cpu, 1);
    chk("R4 no test", test_hiz, 0);
    chk("R8 not yet enabled", outputs_en, 0);
    waitn((LOCK + 2) * TP + 8);
    chk("R8 enabled", outputs_en, 1);

    // R5 one-shot, R7 pd latency, R9 relock
    fsel_pin = 3'b110; pair_sel_pin = 1'b0;
    pg_pin = 1'b1;
    waitn(1);
    chk("R7 pd sync latency", pwr_down, 0);
    waitn(1);
    chk("R7 pd live", pwr_down, 1);
    chk("R9 en off in pd", outputs_en, 0);
    waitn(4);
    pg_pin = 1'b0;
    waitn(2);
    chk("R7 pd released", pwr_down, 0);
    chk("R5 fsel kept", fsel_q, 3'b011);
    chk("R5 pair kept", pair_is_cpu, 1);
    waitn((LOCK - 1) * TP);
    chk("R9 relock wait", outputs_en, 0);
    waitn(TP + 8);
    chk("R9 relocked", outputs_en, 1);

    // R10: supply drop clears and rearms
    avdd_ok = 1'b0;
    waitn(1);
    check_off("R10 drop");
    power_up(3'b100, 1'b0, 1'b0);
    chk("R10 fresh code", freq_code, 5);
    chk("R10 fresh en", outputs_en, 1);

    // R9: power-down right after the latch, before lock
    avdd_ok = 1'b0; pg_pin = 1'b1; waitn(2);
    fsel_pin = 3'b001; tsel_pin = 1'b0; pg_pin = 1'b0; avdd_ok = 1'b1;
    waitn(SUP * TP + 8);
    pg_pin = 1'b1;
    waitn(2 * LOCK * TP);
    chk("R9 early pd no enable", outputs_en, 0);
    chk("R9 early pd live", pwr_down, 1);
    chk("R9 early pd code", freq_code, 1);
    pg_pin = 1'b0;
    waitn((LOCK + 2) * TP + 8);
    chk("R9 enable after early pd", outputs_en, 1);

    // R6: test mode keeps the strobe live
    power_up(3'b101, 1'b1, 1'b0);
    chk("R4 test strap", test_hiz, 1);
    fsel_pin = 3'b110; pair_sel_pin = 1'b1;
    waitn(2);
    chk("R6 reload fsel", fsel_q, 3'b110);
    chk("R6 reload pair", pair_is_cpu, 1);
    chk("R6 reload code", freq_code, 6);
    tsel_pin = 1'b0;
    waitn(2);
    chk("R6 leave test", test_hiz, 0);
    fsel_pin = 3'b001;
    waitn(3);
    chk("R5 held after test", fsel_q, 3'b110);

    // R2: every code, directed
    for (int v = 0; v < 8; v++) begin
      power_up(3'(v), 1'b0, 1'(v & 1));
      chk($sformatf("R2 code %0d", v), freq_code, exp_code(3'(v)));
      chk($sformatf("R4 fsel %0d", v), fsel_q, v);
    end

    // random power cycles
    for (int i = 0; i < 12; i++) begin
      logic [2:0] f;
      logic p;
      f = 3'($urandom_range(0, 7));
      p = 1'($urandom_range(0, 1));
      power_up(f, 1'b0, p);
      chk("R2 rand code", freq_code, exp_code(f));
      chk("R4 rand pair", pair_is_cpu, p);
      chk("R8 rand en", outputs_en, 1);
      if ($urandom_range(0, 1) == 1) begin
        fsel_pin = ~f;
        pg_pin = 1'b1; waitn(3); pg_pin = 1'b0; waitn(3);
        chk("R5 rand hold", fsel_q, f);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule